// File: doc/BRIEF.md
# Priority and Mask Interrupt Arbiter

This block chooses which of a set of pending interrupt requests is presented to the CPU. Each maskable source has one programmable priority bit. A 2-bit control-mode field and the CPU's two mask bits (a primary mask `mask_i` and a secondary mask `mask_ui`) together form a three-level mask. A non-maskable request overrides every mask and wins over all other sources. The block registers its decision into a request strobe, a winning source number and a vector index. It then holds that result until the CPU acknowledges it.

A set of key-input group requests (`N_KEY` lines) is handled in one of two ways, chosen by a vector-mode bit. In compatible mode each key group shares a regular source slot and that slot's vector. In extended mode each key group becomes a source of its own, with a dedicated vector number. Edge and level detection, CPU state stacking and the CPU's own mask updates on acceptance are done elsewhere.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request pending, `irq_req`, `irq_src` and `irq_vec` are all zero.
- R2: A high `nmi` wins whatever the mode, mask and priority inputs are. It gives source number `N_SRC+N_KEY` (18 by default) and vector `VEC_NMI` (7).
- R3: Simple control mode is any `ctl_mode` value other than 2'b10. In this mode `mask_i`=1 blocks every maskable source and `mask_i`=0 accepts all of them. `mask_ui` has no effect.
- R4: Priority control mode is `ctl_mode`=2'b10. `mask_i`=0 accepts every source. `mask_i`=1 with `mask_ui`=0 accepts only sources whose priority bit is 1. `mask_i`=1 with `mask_ui`=1 accepts no maskable source.
- R5: Among the accepted sources, one with priority bit 1 beats any with priority bit 0. Within the same priority level, the lowest source number wins.
- R6: With `vec_mode`=0 (compatible), `key_req[k]` is ORed into source `KEY_BASE+k` (6 and 7 by default). Regular source `s` gets vector `VEC_BASE+s` (16+s).
- R7: With `vec_mode`=1 (extended), `key_req[k]` is source `N_SRC+k` (16 and 17 by default), takes its priority from `prio[KEY_BASE+k]`, and gets vector `VEC_KEY+k` (104+k). Within a priority level it ranks below every regular source.
- R8: When idle, the decision taken from the inputs in one cycle appears on `irq_req`, `irq_src` and `irq_vec` after the next rising clock edge.
- R9: While `irq_req` is high and `irq_ack` is low, `irq_req`, `irq_src` and `irq_vec` hold their values, even if the inputs change.
- R10: A clock edge with `irq_req` and `irq_ack` both high clears `irq_req`. The next edge then takes a new decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi | input | 1 | Non-maskable request, pending level |
| src_req | input | N_SRC | Pending maskable requests |
| key_req | input | N_KEY | Pending key-input group requests |
| prio | input | N_SRC | Priority bit per regular source |
| ctl_mode | input | 2 | Control mode: 2'b10 priority, other values simple |
| mask_i | input | 1 | CPU primary mask bit |
| mask_ui | input | 1 | CPU secondary mask bit |
| vec_mode | input | 1 | 0 compatible vectors, 1 extended vectors |
| irq_ack | input | 1 | CPU acceptance of the presented request |
| irq_req | output | 1 | Request strobe to the CPU |
| irq_src | output | $clog2(N_SRC+N_KEY+1) | Winning source number |
| irq_vec | output | VEC_W | Vector index of the winner |

## Verification
All three outputs are due one clock edge after the inputs that produce them, because the decision path is combinational into a single register stage. Once `irq_req` is high, the outputs stay frozen until an edge where `irq_ack` is high. That edge clears the strobe, and a new decision follows one edge later. The driver applies each stimulus just after a falling edge and queues the value expected after the following rising edge. The monitor compares that value two nanoseconds after the rising edge. It checks the source and vector only when the strobe is expected high.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam logic [1:0] CTL_PRIORITY = 2'b10;

   typedef struct packed {
      logic accept_hi;
      logic accept_lo;
   } mask_level_t;

   function automatic mask_level_t decode_mask(input logic [1:0] mode,
                                               input logic mi,
                                               input logic mui);
      mask_level_t lv;
      if (mode == CTL_PRIORITY) begin
         lv.accept_lo = ~mi;
         lv.accept_hi = ~(mi & mui);
      end else begin
         lv.accept_lo = ~mi;
         lv.accept_hi = ~mi;
      end
      return lv;
   endfunction
endpackage

// File: rtl/irq_cand_map.sv
module irq_cand_map #(
   parameter int N_SRC    = 16,
   parameter int N_KEY    = 2,
   parameter int KEY_BASE = 6,
   localparam int NC      = N_SRC + N_KEY
) (
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_KEY-1:0] key_req,
   input  logic [N_SRC-1:0] prio,
   input  logic             vec_mode,
   output logic [NC-1:0]    cand,
   output logic [NC-1:0]    cand_prio
);
   for (genvar s = 0; s < N_SRC; s++) begin : g_reg
      if (s >= KEY_BASE && s < KEY_BASE + N_KEY) begin : g_shared
         assign cand[s] = src_req[s] | (key_req[s-KEY_BASE] & ~vec_mode);
      end else begin : g_plain
         assign cand[s] = src_req[s];
      end
      assign cand_prio[s] = prio[s];
   end

   for (genvar k = 0; k < N_KEY; k++) begin : g_key
      assign cand[N_SRC+k]      = key_req[k] & vec_mode;
      assign cand_prio[N_SRC+k] = prio[KEY_BASE+k];
   end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
   import irq_arb_pkg::*;
#(
   parameter int NC = 18
) (
   input  logic [NC-1:0] cand,
   input  logic [NC-1:0] cand_prio,
   input  logic [1:0]    ctl_mode,
   input  logic          mask_i,
   input  logic          mask_ui,
   output logic [NC-1:0] elig_hi,
   output logic [NC-1:0] elig_lo
);
   mask_level_t lv;

   always_comb begin
      lv      = decode_mask(ctl_mode, mask_i, mask_ui);
      elig_hi = cand & cand_prio & {NC{lv.accept_hi}};
      elig_lo = cand & ~cand_prio & {NC{lv.accept_lo}};
   end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
   parameter int W  = 18,
   parameter int IW = 5
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
   parameter int N_SRC    = 16,
   parameter int N_KEY    = 2,
   parameter int VEC_W    = 8,
   parameter int VEC_NMI  = 7,
   parameter int VEC_BASE = 16,
   parameter int VEC_KEY  = 104,
   localparam int SW      = $clog2(N_SRC + N_KEY + 1)
) (
   input  logic          is_nmi,
   input  logic [SW-1:0] src,
   output logic [VEC_W-1:0] vec
);
   logic [VEC_W-1:0] reg_vec;
   logic [VEC_W-1:0] key_vec;
   logic             is_key;

   assign reg_vec = VEC_W'(VEC_BASE) + VEC_W'(src);

   if (N_KEY > 0) begin : g_keyvec
      assign is_key  = (src >= SW'(N_SRC));
      assign key_vec = VEC_W'(VEC_KEY) + VEC_W'(src - SW'(N_SRC));
   end else begin : g_nokey
      assign is_key  = 1'b0;
      assign key_vec = '0;
   end

   always_comb begin
      if (is_nmi)      vec = VEC_W'(VEC_NMI);
      else if (is_key) vec = key_vec;
      else             vec = reg_vec;
   end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
   parameter int N_SRC    = 16,
   parameter int N_KEY    = 2,
   parameter int KEY_BASE = 6,
   parameter int VEC_W    = 8,
   parameter int VEC_NMI  = 7,
   parameter int VEC_BASE = 16,
   parameter int VEC_KEY  = 104,
   localparam int NC      = N_SRC + N_KEY,
   localparam int SW      = $clog2(NC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi,
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_KEY-1:0] key_req,
   input  logic [N_SRC-1:0] prio,
   input  logic [1:0]       ctl_mode,
   input  logic             mask_i,
   input  logic             mask_ui,
   input  logic             vec_mode,
   input  logic             irq_ack,
   output logic             irq_req,
   output logic [SW-1:0]    irq_src,
   output logic [VEC_W-1:0] irq_vec
);
   localparam logic [SW-1:0] NMI_ID = SW'(NC);

   if (N_SRC < 1) begin : g_bad_nsrc
      $error("irq_prio_arbiter: N_SRC must be at least 1");
   end
   if (N_KEY < 1 || KEY_BASE + N_KEY > N_SRC) begin : g_bad_key
      $error("irq_prio_arbiter: key groups must map onto regular sources");
   end
   if (VEC_BASE + N_SRC > (1 << VEC_W) || VEC_KEY + N_KEY > (1 << VEC_W)) begin : g_bad_vec
      $error("irq_prio_arbiter: vector range exceeds VEC_W");
   end

   logic [NC-1:0] cand, cand_prio, elig_hi, elig_lo;
   logic          hi_found, lo_found;
   logic [SW-1:0] hi_idx, lo_idx, win_src;
   logic          win_any;
   logic [VEC_W-1:0] win_vec;

   irq_cand_map #(.N_SRC(N_SRC), .N_KEY(N_KEY), .KEY_BASE(KEY_BASE)) map_i (
      .src_req(src_req), .key_req(key_req), .prio(prio), .vec_mode(vec_mode),
      .cand(cand), .cand_prio(cand_prio)
   );

   irq_mask_gate #(.NC(NC)) gate_i (
      .cand(cand), .cand_prio(cand_prio), .ctl_mode(ctl_mode),
      .mask_i(mask_i), .mask_ui(mask_ui),
      .elig_hi(elig_hi), .elig_lo(elig_lo)
   );

   irq_first_set #(.W(NC), .IW(SW)) pick_hi_i (
      .vec(elig_hi), .found(hi_found), .idx(hi_idx)
   );

   irq_first_set #(.W(NC), .IW(SW)) pick_lo_i (
      .vec(elig_lo), .found(lo_found), .idx(lo_idx)
   );

   always_comb begin
      win_any = nmi | hi_found | lo_found;
      if (nmi)           win_src = NMI_ID;
      else if (hi_found) win_src = hi_idx;
      else               win_src = lo_idx;
   end

   irq_vec_map #(
      .N_SRC(N_SRC), .N_KEY(N_KEY), .VEC_W(VEC_W),
      .VEC_NMI(VEC_NMI), .VEC_BASE(VEC_BASE), .VEC_KEY(VEC_KEY)
   ) vmap_i (
      .is_nmi(nmi), .src(win_src), .vec(win_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_src <= '0;
         irq_vec <= '0;
      end else if (irq_req) begin
         if (irq_ack) irq_req <= 1'b0;
      end else begin
         irq_req <= win_any;
         if (win_any) begin
            irq_src <= win_src;
            irq_vec <= win_vec;
         end
      end
   end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
   parameter int N_SRC    = 16,
   parameter int N_KEY    = 2,
   parameter int VEC_W    = 8,
   parameter int VEC_NMI  = 7,
   parameter int VEC_BASE = 16,
   parameter int VEC_KEY  = 104,
   localparam int NC      = N_SRC + N_KEY,
   localparam int SW      = $clog2(NC + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             nmi,
   input logic [N_SRC-1:0] src_req,
   input logic [N_KEY-1:0] key_req,
   input logic [1:0]       ctl_mode,
   input logic             mask_i,
   input logic             mask_ui,
   input logic             irq_ack,
   input logic             irq_req,
   input logic [SW-1:0]    irq_src,
   input logic [VEC_W-1:0] irq_vec
);
   assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi && !irq_req) |=> (irq_req && irq_src == SW'(NC) && irq_vec == VEC_W'(VEC_NMI)));

   assert_simple_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req && !nmi && ctl_mode != 2'b10 && mask_i) |=> !irq_req);

   assert_full_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req && !nmi && ctl_mode == 2'b10 && mask_i && mask_ui) |=> !irq_req);

   assert_reg_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_src < SW'(N_SRC)) |-> (irq_vec == VEC_W'(VEC_BASE) + VEC_W'(irq_src)));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req && !nmi && src_req == '0 && key_req == '0) |=> !irq_req);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> (irq_req && $stable(irq_src) && $stable(irq_vec)));

   assert_ack_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> !irq_req);
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
   .N_SRC(N_SRC), .N_KEY(N_KEY), .VEC_W(VEC_W),
   .VEC_NMI(VEC_NMI), .VEC_BASE(VEC_BASE), .VEC_KEY(VEC_KEY)
) chk_i (
   .clk(clk), .rst_n(rst_n), .nmi(nmi), .src_req(src_req), .key_req(key_req),
   .ctl_mode(ctl_mode), .mask_i(mask_i), .mask_ui(mask_ui), .irq_ack(irq_ack),
   .irq_req(irq_req), .irq_src(irq_src), .irq_vec(irq_vec)
);

// File: tb/irq_prio_arbiter_tb_top.sv
module irq_prio_arbiter_tb_top;
   typedef struct {
      logic       req;
      int         src;
      int         vec;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi = 1'b0;
   logic [15:0] src_req = '0;
   logic [1:0]  key_req = '0;
   logic [15:0] prio = '0;
   logic [1:0]  ctl_mode = 2'b00;
   logic        mask_i = 1'b0;
   logic        mask_ui = 1'b0;
   logic        vec_mode = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq_req;
   logic [4:0]  irq_src;
   logic [7:0]  irq_vec;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   irq_prio_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .nmi(nmi), .src_req(src_req), .key_req(key_req),
      .prio(prio), .ctl_mode(ctl_mode), .mask_i(mask_i), .mask_ui(mask_ui),
      .vec_mode(vec_mode), .irq_ack(irq_ack),
      .irq_req(irq_req), .irq_src(irq_src), .irq_vec(irq_vec)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic step(input logic ack, input logic e_req, input int e_src,
                       input int e_vec, input string tag);
      exp_t e;
      irq_ack = ack;
      e.req = e_req; e.src = e_src; e.vec = e_vec; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic release_req(input string tag);
      step(1'b1, 1'b0, 0, 0, tag);
      irq_ack = 1'b0;
   endtask

   always begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(irq_req == e.req, e.tag, "irq_req", int'(irq_req), int'(e.req));
         if (e.req) begin
            check(int'(irq_src) == e.src, e.tag, "irq_src", int'(irq_src), e.src);
            check(int'(irq_vec) == e.vec, e.tag, "irq_vec", int'(irq_vec), e.vec);
         end
      end
   end

   initial begin
      #40000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(irq_req == 1'b0 && irq_src == '0 && irq_vec == '0, "R1", "reset outputs",
            int'(irq_req) + int'(irq_src) + int'(irq_vec), 0);
      rst_n = 1'b1;
      @(negedge clk);
      step(1'b0, 1'b0, 0, 0, "R1");

      // R8: single source, simple mode, one edge latency
      src_req = 16'h0008;
      step(1'b0, 1'b1, 3, 19, "R8");
      // R9: input change while pending is held
      src_req = 16'h0002;
      step(1'b0, 1'b1, 3, 19, "R9");
      // R10: ack clears, then re-decision
      step(1'b1, 1'b0, 0, 0, "R10");
      step(1'b0, 1'b1, 1, 17, "R10");
      release_req("R10");

      // R5: priority-1 beats lower number at priority 0
      src_req = 16'h0204; prio = 16'h0200;
      step(1'b0, 1'b1, 9, 25, "R5");
      release_req("R5");
      src_req = 16'h0030; prio = 16'h0000;
      step(1'b0, 1'b1, 4, 20, "R5");
      release_req("R5");

      // R3: simple mode masking
      src_req = 16'h0004; prio = 16'h0004; mask_i = 1'b1;
      step(1'b0, 1'b0, 0, 0, "R3");
      ctl_mode = 2'b01;
      step(1'b0, 1'b0, 0, 0, "R3");
      ctl_mode = 2'b00; mask_i = 1'b0; mask_ui = 1'b1;
      step(1'b0, 1'b1, 2, 18, "R3");
      release_req("R3");

      // R4: priority mode three levels
      ctl_mode = 2'b10; mask_i = 1'b1; mask_ui = 1'b0;
      src_req = 16'h0024; prio = 16'h0020;
      step(1'b0, 1'b1, 5, 21, "R4");
      release_req("R4");
      prio = 16'h0000;
      step(1'b0, 1'b0, 0, 0, "R4");
      prio = 16'h0020; mask_ui = 1'b1;
      step(1'b0, 1'b0, 0, 0, "R4");
      mask_i = 1'b0; prio = 16'h0000;
      step(1'b0, 1'b1, 2, 18, "R4");
      release_req("R4");

      // R2: NMI bypasses masks
      mask_i = 1'b1; mask_ui = 1'b1; nmi = 1'b1;
      step(1'b0, 1'b1, 18, 7, "R2");
      release_req("R2");
      ctl_mode = 2'b00; mask_ui = 1'b0; prio = 16'hFFFF;
      step(1'b0, 1'b1, 18, 7, "R2");
      nmi = 1'b0;
      release_req("R2");

      // R6: compatible vectors, key groups share sources 6 and 7
      mask_i = 1'b0; prio = '0; src_req = '0; vec_mode = 1'b0;
      key_req = 2'b01;
      step(1'b0, 1'b1, 6, 22, "R6");
      release_req("R6");
      key_req = 2'b10;
      step(1'b0, 1'b1, 7, 23, "R6");
      release_req("R6");

      // R7: extended vectors, key groups are own sources
      vec_mode = 1'b1; key_req = 2'b01;
      step(1'b0, 1'b1, 16, 104, "R7");
      release_req("R7");
      src_req = 16'h0400;
      step(1'b0, 1'b1, 10, 26, "R7");
      release_req("R7");
      key_req = 2'b10; prio = 16'h0080;
      step(1'b0, 1'b1, 17, 105, "R7");
      release_req("R7");
      key_req = 2'b00; src_req = 16'h0000;
      step(1'b0, 1'b0, 0, 0, "R7");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule